// File: doc/BRIEF.md
# Clock Loss Monitor with Source Select

This block watches the two clocks that drive a PLL's phase detector, the reference clock and the feedback clock, using a free-running monitor clock. Each watched clock is brought into the monitor domain through a short synchronizer chain. Its rising edges are then counted over fixed windows of `WIN` monitor cycles. If a clock shows fewer than `MIN_EDGES` edges in a window, it is judged dead for that window.

Two flags report a failure. A live flag follows the result of the latest window and drops again once edges come back. A sticky flag holds a failure until reset or until a clear pulse.

The block also produces a two-bit source select for a downstream clock switch. That select moves to whichever clock still works, and it stays there until reset. The block drives only the select decision; the glitch-free switching itself is done elsewhere. Detection is active only while the enable is high and the PLL-off mode input is low.

Top module: `clkloss_monitor`

## Requirements
- R1: After a synchronous reset, `loss_live` is 0, `loss_sticky` is 0 and `src_sel` is 00.
- R2: Detection is active only when `en` is 1 and `pll_off` is 0. While it is inactive, the window timer and edge counts are held cleared and `loss_live` is 0 from the next monitor edge on. The sticky flag is not set and `src_sel` does not change.
- R3: A watched clock is failed for a window when fewer than `MIN_EDGES` synchronized rising edges are counted in that window of `WIN` monitor cycles. Exactly `MIN_EDGES` edges is not a failure. The first window closes on the `WIN`-th monitor edge after reset, and `loss_live` takes the new result on that edge.
- R4: `loss_live` returns to 0 at the close of the first window in which both clocks show enough edges.
- R5: `loss_sticky` is set one monitor edge after `loss_live` is seen high while detection is active. It stays set after `loss_live` clears.
- R6: A one-cycle `clr_sticky` pulse clears `loss_sticky` on the next edge when no failure is flagged. If a failure is flagged in that same cycle, the sticky flag stays set.
- R7: `src_sel` uses these codes: 00 = PLL output, 01 = reference-derived output (the feedback clock failed), 10 = monitor/crystal fallback (the reference clock failed). If both clocks fail, 10 wins. The select changes one edge after the failure appears on `loss_live`.
- R8: Once `src_sel` leaves 00, it keeps its value until reset. This holds even if the clocks recover or detection is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Detection enable |
| pll_off | input | 1 | PLL-off mode; disables detection |
| clr_sticky | input | 1 | Pulse that clears the sticky flag |
| ref_clk_in | input | 1 | Watched reference clock, asynchronous |
| fb_clk_in | input | 1 | Watched feedback clock, asynchronous |
| loss_live | output | 1 | Failure seen in the latest window |
| loss_sticky | output | 1 | Latched failure indication |
| src_sel | output | 2 | Output source select code |

## Verification
`loss_live` takes a window's verdict on the `WIN`-th edge of that window. `loss_sticky` and `src_sel` follow one edge later, and disabling detection clears `loss_live` one edge after the disable is sampled. The bench counts monitor edges from the release of reset and samples at the falling edge that follows the edge where a result is due. For example, it checks edge 31 against edge 32 and edge 32 against edge 33, so each latency is pinned to an exact cycle. Edge-count boundary tests place their input pulses well inside a window. This keeps the three-cycle synchronizer delay from moving any pulse across a window boundary.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  typedef enum logic [1:0] {
    SEL_PLL  = 2'b00,
    SEL_REF  = 2'b01,
    SEL_XTAL = 2'b10
  } src_sel_e;

  localparam int NUM_MON = 2;
  localparam int IDX_REF = 0;
  localparam int IDX_FB  = 1;

endpackage

// File: rtl/clkloss_edge_sync.sv
module clkloss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R3: a detected edge lasts one monitor cycle, so it is counted once
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/clkloss_win_timer.sv
module clkloss_win_timer #(
  parameter int WIN = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic win_end
);

  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;

  assign win_end = active && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (win_end)   cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assert_window_restart_R3: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (cnt_q == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt_q == '0));

endmodule

// File: rtl/clkloss_edge_tally.sv
module clkloss_edge_tally #(
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic rise,
  input  logic win_end,
  output logic fail
);

  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [CW:0]   MIN_V = (CW+1)'(MIN_EDGES);
  localparam logic [CW-1:0] SAT_V = CW'(MIN_EDGES);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   total;
  logic          fail_q;

  assign total = {1'b0, cnt_q} + {{CW{1'b0}}, rise};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (win_end) begin
      fail_q <= (total < MIN_V);
      cnt_q  <= '0;
    end else if (rise && (cnt_q != SAT_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fail = fail_q;

  // R3: a verdict changes only at a window close
  assert_verdict_at_close_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(win_end));

  // R2: no verdict survives a disable
  assert_clear_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> !fail_q);

endmodule

// File: rtl/clkloss_monitor.sv
module clkloss_monitor
  import clkloss_pkg::*;
#(
  parameter int WIN         = 256,
  parameter int MIN_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       pll_off,
  input  logic       clr_sticky,
  input  logic       ref_clk_in,
  input  logic       fb_clk_in,
  output logic       loss_live,
  output logic       loss_sticky,
  output logic [1:0] src_sel
);

  logic                active;
  logic                win_end;
  logic [NUM_MON-1:0]  mon_in;
  logic [NUM_MON-1:0]  rise;
  logic [NUM_MON-1:0]  fail;
  logic                fail_any;
  logic                sticky_q;
  src_sel_e            sel_q;

  assign active = en & ~pll_off;
  assign mon_in[IDX_REF] = ref_clk_in;
  assign mon_in[IDX_FB]  = fb_clk_in;

  clkloss_win_timer #(.WIN(WIN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .win_end (win_end)
  );

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    clkloss_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (mon_in[g]),
      .rise (rise[g])
    );
    clkloss_edge_tally #(.MIN_EDGES(MIN_EDGES)) u_tally (
      .clk     (clk),
      .rst     (rst),
      .active  (active),
      .rise    (rise[g]),
      .win_end (win_end),
      .fail    (fail[g])
    );
  end

  assign fail_any = |fail;

  always_ff @(posedge clk) begin
    if (rst)                       sticky_q <= 1'b0;
    else if (active && fail_any)   sticky_q <= 1'b1;
    else if (clr_sticky)           sticky_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_PLL;
    end else if (sel_q == SEL_PLL && active) begin
      if (fail[IDX_REF])     sel_q <= SEL_XTAL;
      else if (fail[IDX_FB]) sel_q <= SEL_REF;
    end
  end

  assign loss_live   = fail_any;
  assign loss_sticky = sticky_q;
  assign src_sel     = sel_q;

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> !loss_live);

  assert_sticky_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (active && loss_live) |=> loss_sticky);

  assert_sel_no_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_PLL && !fail_any) |=> (src_sel == 2'b00));

  assert_ref_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_PLL && active && fail[IDX_REF]) |=> (src_sel == 2'b10));

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (src_sel != 2'b00) |=> $stable(src_sel));

  assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
    src_sel != 2'b11);

endmodule

// File: tb/sim_clkloss_monitor.sv
module sim_clkloss_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 32;
  localparam int MIN_EDGES  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, pll_off = 1'b0, clr_sticky = 1'b0;
  logic ref_run = 1'b0, fb_run = 1'b0, ref_man = 1'b0;
  logic gen_clk;
  logic [7:0] gen_cnt = '0;
  logic ref_clk_in, fb_clk_in;
  logic loss_live, loss_sticky;
  logic [1:0] src_sel;
  int ecount = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) gen_cnt <= gen_cnt + 1'b1;
  assign gen_clk    = gen_cnt[1];
  assign ref_clk_in = ref_run ? gen_clk : ref_man;
  assign fb_clk_in  = fb_run  ? gen_clk : 1'b0;

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  clkloss_monitor #(.WIN(WIN), .MIN_EDGES(MIN_EDGES)) u0 (
    .clk(clk), .rst(rst), .en(en), .pll_off(pll_off), .clr_sticky(clr_sticky),
    .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
    .loss_live(loss_live), .loss_sticky(loss_sticky), .src_sel(src_sel)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (edge %0d)", req, act, exp, ecount);
    end
  endtask

  task automatic do_reset(input logic r_run, input logic f_run, input logic e, input logic off);
    @(negedge clk);
    rst = 1'b1; ref_run = r_run; fb_run = f_run; en = e; pll_off = off;
    ref_man = 1'b0; clr_sticky = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic at_edge(input int k);
    while (ecount < k) @(negedge clk);
  endtask

  function automatic logic [3:0] expect_out(input logic r_ok, input logic f_ok,
                                            input logic e, input logic off);
    logic act, live;
    logic [1:0] sel;
    act  = e & ~off;
    live = act & (~r_ok | ~f_ok);
    sel  = !act ? 2'b00 : (!r_ok ? 2'b10 : (!f_ok ? 2'b01 : 2'b00));
    return {live, live, sel};
  endfunction

  task automatic pulses_test(input int n);
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    at_edge(36);
    for (int i = 0; i < n; i++) begin
      ref_man = 1'b1; @(negedge clk);
      ref_man = 1'b0; @(negedge clk); @(negedge clk);
    end
    at_edge(64);
    chk($sformatf("R3 %0d edges in window", n), {1'b0, loss_live}, {1'b0, (n < MIN_EDGES)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] ex;
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 live", {1'b0, loss_live}, 2'b00);
    chk("R1 sticky", {1'b0, loss_sticky}, 2'b00);
    chk("R1 sel", src_sel, 2'b00);

    // R3/R5/R7 latency, reference dead
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    at_edge(31);
    chk("R3 live before close", {1'b0, loss_live}, 2'b00);
    at_edge(32);
    chk("R3 live at close", {1'b0, loss_live}, 2'b01);
    chk("R7 sel not yet", src_sel, 2'b00);
    chk("R5 sticky not yet", {1'b0, loss_sticky}, 2'b00);
    at_edge(33);
    chk("R7 sel ref dead", src_sel, 2'b10);
    chk("R5 sticky set", {1'b0, loss_sticky}, 2'b01);
    // R2 disable clears live next edge, R8 select held
    en = 1'b0;
    @(negedge clk);
    chk("R2 live cleared on disable", {1'b0, loss_live}, 2'b00);
    chk("R8 sel held while disabled", src_sel, 2'b10);
    chk("R5 sticky held", {1'b0, loss_sticky}, 2'b01);

    // R7 feedback dead; R4 recovery; R8 hold; R6 clear
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    at_edge(33);
    chk("R7 sel fb dead", src_sel, 2'b01);
    fb_run = 1'b1;
    at_edge(64);
    chk("R4 live clears on recovery", {1'b0, loss_live}, 2'b00);
    chk("R8 sel held after recovery", src_sel, 2'b01);
    chk("R5 sticky after recovery", {1'b0, loss_sticky}, 2'b01);
    clr_sticky = 1'b1; @(negedge clk); clr_sticky = 1'b0;
    chk("R6 sticky cleared", {1'b0, loss_sticky}, 2'b00);
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    at_edge(40);
    chk("R8 reset returns sel", src_sel, 2'b00);

    // R7 both dead: reference priority
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    at_edge(34);
    chk("R7 both dead priority", src_sel, 2'b10);
    // R6 clear ignored while failure live
    clr_sticky = 1'b1; @(negedge clk); clr_sticky = 1'b0;
    chk("R6 clear while live", {1'b0, loss_sticky}, 2'b01);

    // R2 detection off by enable and by PLL-off mode
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    at_edge(70);
    chk("R2 en low live", {1'b0, loss_live}, 2'b00);
    chk("R2 en low sel", src_sel, 2'b00);
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    at_edge(70);
    chk("R2 pll_off sticky", {1'b0, loss_sticky}, 2'b00);
    chk("R2 pll_off sel", src_sel, 2'b00);

    // R3 threshold boundary
    pulses_test(MIN_EDGES);
    pulses_test(MIN_EDGES - 1);

    // random patterns
    for (int it = 0; it < 16; it++) begin
      logic [31:0] r;
      r = $urandom;
      do_reset(r[0], r[1], (r[4:2] != 3'd0), (r[7:5] == 3'd0));
      at_edge(2 * WIN + 2);
      ex = expect_out(r[0], r[1], (r[4:2] != 3'd0), (r[7:5] == 3'd0));
      chk("R3 random live", {1'b0, loss_live}, {1'b0, ex[3]});
      chk("R5 random sticky", {1'b0, loss_sticky}, {1'b0, ex[2]});
      chk("R7 random sel", src_sel, ex[1:0]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule